// File: doc/BRIEF.md
# Reversible-Cell Wallace Multiplier

This block multiplies two unsigned 4-bit operands and returns their 8-bit product. It has no clock and no state, so the product settles from the operands alone. It is meant to sit in a larger datapath wherever a small fixed-width multiply is needed. It can also serve as a structural reference for a multiplier built entirely from reversible logic cells.

Every logic function is built from one three-input, three-output reversible cell. Given inputs A, B and C, the cell drives A on its first output, A XOR B on its second output, and (A AND B) XOR C on its third output.

- With C held low, the cell serves as a 2-input AND gate. It also serves as a half adder, with the second output giving the sum and the third giving the carry.
- Two cells chained together form a full adder that has one extra input tied to zero.

The 16 partial products come from 16 AND-configured cells. A reduction layer of five full adders and three half adders reduces them to three finished low product bits and two 4-bit rows. These rows cover bit weights 3 to 6. A 4-bit ripple adder, made of one half adder and three full adders, merges the two rows, and its carry-out becomes product bit 7. The outputs that carry no result stay inside the cells.

Top module: `rev_wallace_mul`

## Requirements
- R1: For every pair of 4-bit unsigned operands, the 8-bit product equals the arithmetic product of the two operands.
- R2: Product bit 0 equals bit 0 of the first operand AND bit 0 of the second operand.
- R3: When either operand is zero, all eight product bits are zero.
- R4: The product is correct at the known points 14 x 2 = 28 and 9 x 14 = 126. At the largest input, 15 x 15 = 225, bit 7 of the product is set.
- R5: For all eight input combinations, the basic cell with inputs (A, B, C) drives outputs P = A, Q = A XOR B and R = (A AND B) XOR C.
- R6: The half-adder cell, which is the basic cell with C tied low, gives sum = A XOR B and carry = A AND B for all four input pairs.
- R7: For all eight combinations of A, B and carry-in, with its constant input at 0, the full-adder cell gives {carry-out, sum} equal to A + B + carry-in.
- R8: The product follows a change of operands without any clock edge.
- R9: Swapping the two operands leaves the product unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_x | input | 4 | First unsigned operand (multiplicand) |
| op_y | input | 4 | Second unsigned operand (multiplier) |
| product | output | 8 | Unsigned product of op_x and op_y |

## Verification
The assertions are immediate checks inside combinational blocks. They assume that every operand bit carries a settled two-valued level. They also assume that each full adder's constant input is held at zero, because with that input high the cell no longer adds. The bench drives only 0 and 1 values on the operands and ties the constant input of the standalone full-adder cell low. It also waits a full time step after each operand change before sampling.

// File: rtl/mul_pkg.sv
package mul_pkg;

    localparam int OPW    = 4;
    localparam int PW     = 2 * OPW;
    localparam int NPP    = OPW * OPW;
    localparam int ROW_LO = 3;
    localparam int ROW_W  = 4;

    typedef logic [OPW-1:0]   opnd_t;
    typedef logic [PW-1:0]    prod_t;
    typedef logic [NPP-1:0]   ppvec_t;
    typedef logic [ROW_W-1:0] row_t;

    typedef struct packed {
        row_t                row_a;
        row_t                row_b;
        logic [ROW_LO-1:0]   low;
    } reduce_t;

    function automatic int unsigned pp_index(input int unsigned xi, input int unsigned yj);
        return xi * OPW + yj;
    endfunction

    function automatic int unsigned weigh_pp(input ppvec_t v);
        int unsigned tot;
        tot = 0;
        for (int i = 0; i < OPW; i++) begin
            for (int j = 0; j < OPW; j++) begin
                tot += int'(v[pp_index(i, j)]) << (i + j);
            end
        end
        return tot;
    endfunction

endpackage

// File: rtl/rev_cell.sv
module rev_cell (
    input  logic a,
    input  logic b,
    input  logic c,
    output logic p,
    output logic q,
    output logic r
);
    assign p = a;
    assign q = a ^ b;
    assign r = (a & b) ^ c;
endmodule

// File: rtl/rev_and.sv
module rev_and (
    input  logic a,
    input  logic b,
    output logic y
);
    logic p_pass;
    logic q_pass;

    rev_cell u_cell (
        .a (a),
        .b (b),
        .c (1'b0),
        .p (p_pass),
        .q (q_pass),
        .r (y)
    );

    always_comb begin
        if (y) begin
            assert_and_pass_R5: assert (p_pass && !q_pass)
                else $error("AND cell high with inconsistent pass outputs");
        end
    end
endmodule

// File: rtl/rev_ha.sv
module rev_ha (
    input  logic a,
    input  logic b,
    output logic sum,
    output logic carry
);
    logic p_pass;

    rev_cell u_cell (
        .a (a),
        .b (b),
        .c (1'b0),
        .p (p_pass),
        .q (sum),
        .r (carry)
    );

    always_comb begin
        assert_ha_total_R6: assert ({carry, sum} == ({1'b0, a} + {1'b0, b}))
            else $error("half adder result wrong");
        if (carry) begin
            assert_ha_pass_R6: assert (p_pass)
                else $error("carry without A set");
        end
    end
endmodule

// File: rtl/rev_fa.sv
module rev_fa (
    input  logic a,
    input  logic b,
    input  logic cin,
    input  logic ztie,
    output logic sum,
    output logic cout
);
    logic p_first;
    logic x_first;
    logic g_first;
    logic p_second;

    rev_cell u_first (
        .a (a),
        .b (b),
        .c (ztie),
        .p (p_first),
        .q (x_first),
        .r (g_first)
    );

    rev_cell u_second (
        .a (x_first),
        .b (cin),
        .c (g_first),
        .p (p_second),
        .q (sum),
        .r (cout)
    );

    always_comb begin
        if (!ztie) begin
            assert_fa_total_R7: assert ({cout, sum} == ({1'b0, a} + {1'b0, b} + {1'b0, cin}))
                else $error("full adder result wrong");
        end
        assert_fa_recover_R7: assert ((p_first ^ p_second) == b)
            else $error("pass outputs do not recover B");
    end
endmodule

// File: rtl/pp_array.sv
module pp_array
    import mul_pkg::*;
#(
    parameter int W = OPW
) (
    input  logic [W-1:0]   x,
    input  logic [W-1:0]   y,
    output logic [W*W-1:0] ppv
);
    for (genvar i = 0; i < W; i++) begin : g_row
        for (genvar j = 0; j < W; j++) begin : g_col
            rev_and u_and (
                .a (x[i]),
                .b (y[j]),
                .y (ppv[i*W + j])
            );
        end
    end
endmodule

// File: rtl/wallace_reduce.sv
module wallace_reduce
    import mul_pkg::*;
(
    input  ppvec_t  ppv,
    output reduce_t red
);
    localparam logic ZT = 1'b0;

    logic s1, c1;
    logic s2a, c2a, s2b, c2b;
    logic s3a, c3a, s3b, c3b;
    logic s4a, c4a, s4b, c4b;
    logic s5, c5;

    // weight 1
    rev_ha u_ha_w1  (.a(ppv[pp_index(0,1)]), .b(ppv[pp_index(1,0)]), .sum(s1), .carry(c1));
    // weight 2: three products, then fold in the weight-1 carry
    rev_fa u_fa_w2  (.a(ppv[pp_index(0,2)]), .b(ppv[pp_index(1,1)]), .cin(ppv[pp_index(2,0)]),
                     .ztie(ZT), .sum(s2a), .cout(c2a));
    rev_ha u_ha_w2  (.a(s2a), .b(c1), .sum(s2b), .carry(c2b));
    // weight 3: four products plus two carries -> two bits
    rev_fa u_fa_w3a (.a(ppv[pp_index(0,3)]), .b(ppv[pp_index(1,2)]), .cin(ppv[pp_index(2,1)]),
                     .ztie(ZT), .sum(s3a), .cout(c3a));
    rev_fa u_fa_w3b (.a(ppv[pp_index(3,0)]), .b(c2a), .cin(c2b),
                     .ztie(ZT), .sum(s3b), .cout(c3b));
    // weight 4: three products plus two carries -> two bits
    rev_fa u_fa_w4  (.a(ppv[pp_index(1,3)]), .b(ppv[pp_index(2,2)]), .cin(ppv[pp_index(3,1)]),
                     .ztie(ZT), .sum(s4a), .cout(c4a));
    rev_ha u_ha_w4  (.a(s4a), .b(c3a), .sum(s4b), .carry(c4b));
    // weight 5: two products plus one carry
    rev_fa u_fa_w5  (.a(ppv[pp_index(2,3)]), .b(ppv[pp_index(3,2)]), .cin(c4a),
                     .ztie(ZT), .sum(s5), .cout(c5));

    always_comb begin
        red.low   = {s2b, s1, ppv[pp_index(0,0)]};
        red.row_a = {ppv[pp_index(3,3)], s5, s4b, s3a};
        red.row_b = {c5, c4b, c3b, s3b};
    end

    always_comb begin
        assert_reduce_keeps_value_R1: assert (weigh_pp(ppv) ==
                int'(red.low) + ((int'(red.row_a) + int'(red.row_b)) << ROW_LO))
            else $error("reduction changed the weighted sum");
    end
endmodule

// File: rtl/ripple_add.sv
module ripple_add #(
    parameter int RW = 4
) (
    input  logic [RW-1:0] a,
    input  logic [RW-1:0] b,
    output logic [RW-1:0] sum,
    output logic          cout
);
    logic [RW-1:0] cy;

    for (genvar k = 0; k < RW; k++) begin : g_bit
        if (k == 0) begin : g_head
            rev_ha u_ha (.a(a[k]), .b(b[k]), .sum(sum[k]), .carry(cy[k]));
        end else begin : g_body
            rev_fa u_fa (.a(a[k]), .b(b[k]), .cin(cy[k-1]), .ztie(1'b0),
                         .sum(sum[k]), .cout(cy[k]));
        end
    end

    assign cout = cy[RW-1];

    always_comb begin
        assert_ripple_total_R1: assert ({cout, sum} == ({1'b0, a} + {1'b0, b}))
            else $error("ripple merge result wrong");
    end
endmodule

// File: rtl/rev_wallace_mul.sv
module rev_wallace_mul
    import mul_pkg::*;
(
    input  logic [3:0] op_x,
    input  logic [3:0] op_y,
    output logic [7:0] product
);
    ppvec_t  ppv;
    reduce_t red;
    row_t    merged;
    logic    top_carry;

    pp_array #(.W(OPW)) u_pp (
        .x   (op_x),
        .y   (op_y),
        .ppv (ppv)
    );

    wallace_reduce u_red (
        .ppv (ppv),
        .red (red)
    );

    ripple_add #(.RW(ROW_W)) u_merge (
        .a    (red.row_a),
        .b    (red.row_b),
        .sum  (merged),
        .cout (top_carry)
    );

    assign product = {top_carry, merged, red.low};

    always_comb begin
        assert_product_value_R1: assert (product == ({4'b0, op_x} * {4'b0, op_y}))
            else $error("product mismatch");
        assert_low_bit_R2: assert (product[0] == (op_x[0] & op_y[0]))
            else $error("bit 0 mismatch");
        if (op_x == '0 || op_y == '0) begin
            assert_zero_operand_R3: assert (product == '0)
                else $error("zero operand gave nonzero product");
        end
    end
endmodule

// File: tb/test_rev_wallace_mul.sv
module test_rev_wallace_mul;

    logic       clk = 1'b0;
    int         checks = 0;
    int         errors = 0;
    int         cycles = 0;
    bit         done = 1'b0;

    logic [3:0] op_x = '0;
    logic [3:0] op_y = '0;
    logic [7:0] product;

    logic c_a = 0, c_b = 0, c_c = 0;
    logic c_p, c_q, c_r;
    logic h_a = 0, h_b = 0;
    logic h_s, h_c;
    logic f_a = 0, f_b = 0, f_ci = 0;
    logic f_s, f_co;

    always #2.5 clk = ~clk;

    rev_wallace_mul i_rev_wallace_mul (.op_x(op_x), .op_y(op_y), .product(product));
    rev_cell i_cell (.a(c_a), .b(c_b), .c(c_c), .p(c_p), .q(c_q), .r(c_r));
    rev_ha   i_ha   (.a(h_a), .b(h_b), .sum(h_s), .carry(h_c));
    rev_fa   i_fa   (.a(f_a), .b(f_b), .cin(f_ci), .ztie(1'b0), .sum(f_s), .cout(f_co));

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic apply(input int x, input int y);
        op_x = 4'(x);
        op_y = 4'(y);
        #1;
    endtask

    task automatic t_zero;
        apply(0, 0);
        chk("R3 zero/zero", int'(product), 0);
        for (int v = 0; v < 16; v++) begin
            apply(v, 0);
            chk("R3 x*0", int'(product), 0);
            apply(0, v);
            chk("R3 0*y", int'(product), 0);
        end
    endtask

    task automatic t_examples;
        apply(14, 2);
        chk("R4 14x2", int'(product), 28);
        apply(9, 14);
        chk("R4 9x14", int'(product), 126);
        apply(15, 15);
        chk("R4 15x15", int'(product), 225);
        chk("R4 bit7", int'(product[7]), 1);
    endtask

    task automatic t_exhaustive;
        for (int x = 0; x < 16; x++) begin
            for (int y = 0; y < 16; y++) begin
                apply(x, y);
                chk("R1 product", int'(product), x * y);
                chk("R2 bit0", int'(product[0]), (x & y) & 1);
            end
        end
    endtask

    task automatic t_swap;
        int fwd;
        for (int x = 0; x < 16; x++) begin
            for (int y = x + 1; y < 16; y += 3) begin
                apply(x, y);
                fwd = int'(product);
                apply(y, x);
                chk("R9 swap", int'(product), fwd);
            end
        end
    endtask

    task automatic t_nocLock;
        @(posedge clk);
        #0.5;
        apply(7, 13);
        chk("R8 settle between edges", int'(product), 91);
        apply(12, 11);
        chk("R8 second change", int'(product), 132);
    endtask

    task automatic t_cell;
        for (int v = 0; v < 8; v++) begin
            c_a = v[2]; c_b = v[1]; c_c = v[0];
            #1;
            chk("R5 P", int'(c_p), v[2]);
            chk("R5 Q", int'(c_q), v[2] ^ v[1]);
            chk("R5 R", int'(c_r), (v[2] & v[1]) ^ v[0]);
        end
    endtask

    task automatic t_ha;
        for (int v = 0; v < 4; v++) begin
            h_a = v[1]; h_b = v[0];
            #1;
            chk("R6 sum", int'(h_s), v[1] ^ v[0]);
            chk("R6 carry", int'(h_c), v[1] & v[0]);
        end
    endtask

    task automatic t_fa;
        for (int v = 0; v < 8; v++) begin
            f_a = v[2]; f_b = v[1]; f_ci = v[0];
            #1;
            chk("R7 total", int'({f_co, f_s}), v[2] + v[1] + v[0]);
        end
    endtask

    task automatic report;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 50000 && !done) begin
            errors++;
            $display("FAIL watchdog R1 actual %0d expected %0d", cycles, 50000);
            report();
        end
    end

    initial begin
        #1;
        t_zero();
        t_examples();
        t_exhaustive();
        t_swap();
        t_nocLock();
        t_cell();
        t_ha();
        t_fa();
        done = 1'b1;
        report();
    end

endmodule